// File: doc/BRIEF.md
# Audio DMA Event Interrupt Aggregator

This block gathers per-port event pulses from the audio DMA engines into five event classes and folds them into one interrupt line. Each class has its own status register, where one bit belongs to each port, and its own mask. A status bit is set by its event whether or not that bit is masked. Only unmasked status bits are forwarded to a top-level status register. That register has one bit per class. It has its own clear and mask controls and drives the interrupt line.

Software reaches every register through a plain single-cycle write port and a combinational read port. Playback classes are one port wider than capture classes. The block has no streaming data path, so the bus and the event pulses carry no valid/ready handshake. A write always completes in the cycle it is presented, and a read returns data in the same cycle.

Top module: `aud_irq_agg`

## Requirements
- R1: After reset every status bit reads 0, every implemented mask bit reads 1, and `irq` is 0.
- R2: An event pulse on port p of class c sets bit p of class c's status at the next clock edge. This happens whether or not that bit is masked.
- R3: Writing the clear register of a group clears the status bits where the data is 1 and leaves the bits where it is 0. If an event arrives on a bit in the same cycle as a clear of that bit, the event wins and the bit stays 1.
- R4: A mask-set write sets the mask bits where the data is 1. A mask-clear write clears the mask bits where the data is 1. Data bits that are 0 change nothing. The mask is read back at the mask-set address.
- R5: Address layout. `addr[4:2]` selects the group: 0 is FIFO underflow, 1 is ring underflow, 2 is ring overflow, 3 is free-mark, 4 is full-mark, and 5 is the top level. `addr[1:0]` selects the register: 0 is status (read), 1 is clear (write), 2 is mask set (write) and mask view (read), 3 is mask clear (write). Reads at selector 1 or 3, reads of groups 6 and 7, and reads of bits above a group's width all return 0.
- R6: Top-level bit c is set at the clock edge after class c holds any status bit that is set and unmasked. It stays set until a top-level clear removes it. A class whose set bits are all masked never sets its top-level bit.
- R7: The top-level register clears and masks with the same rules as R3 and R4. `irq` is 1 exactly when some top-level status bit is set and unmasked. `irq` follows a mask change with no added cycle.
- R8: Classes 0, 1 and 3 are playback classes with N_OUT (4) bits. Classes 2 and 4 are capture classes with N_IN (3) bits. The top level has 5 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_fifo_unf | input | N_OUT | Output FIFO underflow pulses, one per playback port |
| evt_ring_unf | input | N_OUT | Ring-buffer underflow pulses, one per playback port |
| evt_ring_ovf | input | N_IN | Ring-buffer overflow pulses, one per capture port |
| evt_free_mark | input | N_OUT | Free-level mark pulses, one per playback port |
| evt_full_mark | input | N_IN | Full-level mark pulses, one per capture port |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data, combinational |
| irq | output | 1 | Merged interrupt |

## Verification
The assertions assume that `rst_n` is held across at least one edge and that inputs carry no unknown values after reset. They also assume one register write per cycle, which a single write port already guarantees. The bench changes every input on the falling edge and reads on the falling edge. Each class and port is swept one at a time, so the value expected at every read comes from a single shifted one. A separate step drives an event and a clear of the same bit in the same cycle, to cover the case where the event must win.

// File: rtl/aud_irq_pkg.sv
package aud_irq_pkg;
  localparam int NUM_CLS = 5;
  localparam int GRP_TOP = 5;
  localparam int NUM_GRP = 6;

  typedef enum logic [1:0] {
    SEL_STAT   = 2'd0,
    SEL_CLR    = 2'd1,
    SEL_MASK   = 2'd2,
    SEL_UNMASK = 2'd3
  } reg_sel_e;

  // Bits per group: capture classes are narrower; the top level has one bit per class.
  function automatic int grp_width(int grp, int n_out, int n_in);
    if (grp == GRP_TOP) return NUM_CLS;
    if (grp == 2 || grp == 4) return n_in;
    return n_out;
  endfunction
endpackage

// File: rtl/aud_evt_bank.sv
module aud_evt_bank #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ev_i,
  input  logic         clr_i,
  input  logic         mset_i,
  input  logic         mclr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] mask_o,
  output logic         pend_o
);
  logic [W-1:0] stat_q, mask_q;
  logic [W-1:0] clr_bits;

  assign clr_bits = clr_i ? wdata_i : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '1;
    end else begin
      // a new event overrides a clear of the same bit
      stat_q <= (stat_q & ~clr_bits) | ev_i;
      if (mset_i)      mask_q <= mask_q | wdata_i;
      else if (mclr_i) mask_q <= mask_q & ~wdata_i;
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign pend_o = |(stat_q & ~mask_q);
endmodule

// File: rtl/aud_irq_agg.sv
module aud_irq_agg
  import aud_irq_pkg::*;
#(
  parameter int N_OUT  = 4,
  parameter int N_IN   = 3,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_OUT-1:0]  evt_fifo_unf,
  input  logic [N_OUT-1:0]  evt_ring_unf,
  input  logic [N_IN-1:0]   evt_ring_ovf,
  input  logic [N_OUT-1:0]  evt_free_mark,
  input  logic [N_IN-1:0]   evt_full_mark,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  localparam int GRP_BITS = ADDR_W - 2;
  localparam int TOP_W    = grp_width(GRP_TOP, N_OUT, N_IN);

  logic [GRP_BITS-1:0] wr_grp, rd_grp;
  reg_sel_e            wr_sel, rd_sel;
  logic [DATA_W-1:0]   grp_stat [NUM_GRP];
  logic [DATA_W-1:0]   grp_mask [NUM_GRP];
  logic [NUM_CLS-1:0]  cls_pend;
  logic                top_pend;
  logic                unused_wr_hi;

  assign wr_grp = wr_addr[ADDR_W-1:2];
  assign wr_sel = reg_sel_e'(wr_addr[1:0]);
  assign rd_grp = rd_addr[ADDR_W-1:2];
  assign rd_sel = reg_sel_e'(rd_addr[1:0]);
  assign unused_wr_hi = ^wr_data;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    localparam int W = grp_width(g, N_OUT, N_IN);
    logic [W-1:0] ev_w, stat_w, mask_w;
    logic         hit, pend_w;

    if (g == 0)      begin : g_e0 assign ev_w = evt_fifo_unf;  end
    else if (g == 1) begin : g_e1 assign ev_w = evt_ring_unf;  end
    else if (g == 2) begin : g_e2 assign ev_w = evt_ring_ovf;  end
    else if (g == 3) begin : g_e3 assign ev_w = evt_free_mark; end
    else if (g == 4) begin : g_e4 assign ev_w = evt_full_mark; end
    else             begin : g_et assign ev_w = cls_pend;      end

    assign hit = wr_en && (wr_grp == GRP_BITS'(g));

    aud_evt_bank #(.W(W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .ev_i    (ev_w),
      .clr_i   (hit && wr_sel == SEL_CLR),
      .mset_i  (hit && wr_sel == SEL_MASK),
      .mclr_i  (hit && wr_sel == SEL_UNMASK),
      .wdata_i (wr_data[W-1:0]),
      .stat_o  (stat_w),
      .mask_o  (mask_w),
      .pend_o  (pend_w)
    );

    assign grp_stat[g] = DATA_W'(stat_w);
    assign grp_mask[g] = DATA_W'(mask_w);

    if (g == GRP_TOP) begin : g_ptop
      assign top_pend = pend_w;
    end else begin : g_pcls
      assign cls_pend[g] = pend_w;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (rd_grp == GRP_BITS'(g)) begin
        if (rd_sel == SEL_STAT)      rd_data = grp_stat[g];
        else if (rd_sel == SEL_MASK) rd_data = grp_mask[g];
      end
    end
  end

  assign irq = top_pend;

  if (TOP_W != NUM_CLS) begin : g_bad_cfg
    $error("top level width must equal class count");
  end
endmodule

// File: rtl/aud_irq_agg_chk.sv
module aud_irq_agg_chk #(
  parameter int N_OUT  = 4,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_OUT-1:0]  evt_fifo_unf,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [N_OUT-1:0]  wr_lo,
  input logic              irq,
  input logic [DATA_W-1:0] stat0,
  input logic [DATA_W-1:0] mask0,
  input logic [DATA_W-1:0] top_stat,
  input logic [DATA_W-1:0] top_mask
);
  localparam logic [ADDR_W-1:0] A_CLR0  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_MSET0 = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_CLRT  = ADDR_W'(21);

  AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_fifo_unf != '0) |=> ((stat0[N_OUT-1:0] & $past(evt_fifo_unf)) == $past(evt_fifo_unf))); // R2

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_CLR0 && evt_fifo_unf == '0) |=> ((stat0[N_OUT-1:0] & $past(wr_lo)) == '0)); // R3

  AST_MASK_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_MSET0) |=> ((mask0[N_OUT-1:0] & $past(wr_lo)) == $past(wr_lo))); // R4

  AST_TOP_FROM_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(top_stat[0]) |-> $past((stat0 & ~mask0) != '0)); // R6

  AST_TOP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (top_stat[0] && !(wr_en && wr_addr == A_CLRT)) |=> top_stat[0]); // R6

  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((top_stat & ~top_mask) != '0)); // R7
endmodule

bind aud_irq_agg aud_irq_agg_chk #(
  .N_OUT(N_OUT), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .evt_fifo_unf (evt_fifo_unf),
  .wr_en        (wr_en),
  .wr_addr      (wr_addr),
  .wr_lo        (wr_data[N_OUT-1:0]),
  .irq          (irq),
  .stat0        (grp_stat[0]),
  .mask0        (grp_mask[0]),
  .top_stat     (grp_stat[5]),
  .top_mask     (grp_mask[5])
);

// File: tb/test_aud_irq_agg.sv
module test_aud_irq_agg;
  localparam int N_OUT = 4;
  localparam int N_IN  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N_OUT-1:0] evt_fifo_unf = '0, evt_ring_unf = '0, evt_free_mark = '0;
  logic [N_IN-1:0]  evt_ring_ovf = '0, evt_full_mark = '0;
  logic       wr_en = 1'b0;
  logic [4:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  aud_irq_agg i_aud_irq_agg (
    .clk(clk), .rst_n(rst_n),
    .evt_fifo_unf(evt_fifo_unf), .evt_ring_unf(evt_ring_unf),
    .evt_ring_ovf(evt_ring_ovf), .evt_free_mark(evt_free_mark),
    .evt_full_mark(evt_full_mark),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  function automatic logic [4:0] ra(int g, int s);
    return 5'(g * 4 + s);
  endfunction

  function automatic int wbits(int g);
    if (g == 5) return 5;
    if (g == 2 || g == 4) return N_IN;
    return N_OUT;
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic set_evt(input int c, input logic [7:0] b);
    case (c)
      0: evt_fifo_unf  = b[N_OUT-1:0];
      1: evt_ring_unf  = b[N_OUT-1:0];
      2: evt_ring_ovf  = b[N_IN-1:0];
      3: evt_free_mark = b[N_OUT-1:0];
      default: evt_full_mark = b[N_IN-1:0];
    endcase
  endtask

  task automatic pulse(input int c, input logic [7:0] b);
    @(negedge clk);
    set_evt(c, b);
    @(negedge clk);
    set_evt(c, 8'h0);
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    // R1 R8: reset values and group widths
    for (int g = 0; g < 6; g++) begin
      rd(ra(g, 2), v); check("R1 R8 reset mask", v, 8'((1 << wbits(g)) - 1));
      rd(ra(g, 0), v); check("R1 reset status", v, 8'h0);
    end
    check("R1 reset irq", {7'h0, irq}, 8'h0);

    // R5: unused selectors and groups read zero
    rd(ra(0, 1), v); check("R5 clear reads zero", v, 8'h0);
    rd(ra(5, 3), v); check("R5 unmask reads zero", v, 8'h0);
    rd(ra(6, 2), v); check("R5 group 6 zero", v, 8'h0);
    rd(ra(7, 0), v); check("R5 group 7 zero", v, 8'h0);
    wr(ra(2, 2), 8'hff); rd(ra(2, 2), v); check("R5 R8 high bits read zero", v, 8'h07);

    wr(ra(5, 3), 8'h1f); tick();
    check("R7 no status no irq", {7'h0, irq}, 8'h0);

    for (int c = 0; c < 5; c++) begin
      for (int p = 0; p < wbits(c); p++) begin
        logic [7:0] pb, cb, full;
        pb = 8'(1 << p); cb = 8'(1 << c); full = 8'((1 << wbits(c)) - 1);
        pulse(c, pb);
        rd(ra(c, 0), v); check("R2 masked event latches", v, pb);
        tick();
        rd(ra(5, 0), v); check("R6 masked class no top", v, 8'h0);
        check("R7 masked no irq", {7'h0, irq}, 8'h0);
        wr(ra(c, 3), pb); tick();
        rd(ra(c, 2), v); check("R4 unmask readback", v, full & ~pb);
        rd(ra(5, 0), v); check("R6 top bit set", v, cb);
        check("R7 irq raised", {7'h0, irq}, 8'h1);
        wr(ra(c, 1), 8'h0);
        rd(ra(c, 0), v); check("R3 zero clear no change", v, pb);
        wr(ra(c, 1), pb);
        rd(ra(c, 0), v); check("R3 clear one", v, 8'h0);
        tick();
        rd(ra(5, 0), v); check("R6 top latched", v, cb);
        wr(ra(5, 2), cb);
        check("R7 top masked irq low", {7'h0, irq}, 8'h0);
        wr(ra(5, 3), cb);
        check("R7 top unmasked irq high", {7'h0, irq}, 8'h1);
        wr(ra(5, 1), cb); tick();
        rd(ra(5, 0), v); check("R7 top clear", v, 8'h0);
        check("R7 irq cleared", {7'h0, irq}, 8'h0);
        wr(ra(c, 2), 8'h0);
        rd(ra(c, 2), v); check("R4 zero mask write no change", v, full & ~pb);
        wr(ra(c, 2), pb);
        rd(ra(c, 2), v); check("R4 remask", v, full);
      end
    end

    // R3: event and clear of the same bit in one cycle, event wins
    pulse(0, 8'h02);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = ra(0, 1); wr_data = 8'h02; evt_fifo_unf = 4'h2;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; evt_fifo_unf = '0;
    rd(ra(0, 0), v); check("R3 event beats clear", v, 8'h02);
    wr(ra(0, 1), 8'h02);
    rd(ra(0, 0), v); check("R3 clear after collision", v, 8'h00);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule